// File: doc/BRIEF.md
# Key Event Queue with Selectable Overflow Policy

This block buffers key press and key release events from a keypad scanner until the host collects them. The scanner offers one 8-bit event per cycle on a push port. The host reads through a pop port that removes the oldest pending event and returns it one cycle later. A count output reports how many events are waiting.

The queue holds ten events. A run-time mode input decides what happens when an event arrives and the queue is already full. In drop mode the new event is lost. In shift mode the oldest event is discarded and the new one is appended. In both modes the arrival is an overflow. An overflow sets a sticky status flag. When the overflow interrupt enable is high, it also sends a one-cycle request to the interrupt logic.

Occupancy is tracked by a three-state controller:
- `Q_EMPTY`: no events are held.
- `Q_PARTIAL`: between one and nine events are held.
- `Q_FULL`: ten events are held.

Its transitions are:
- fill: `Q_EMPTY` to `Q_PARTIAL`, on a push.
- drain: `Q_PARTIAL` to `Q_EMPTY`, when the last event is popped.
- top-off: `Q_PARTIAL` to `Q_FULL`, when the tenth event is pushed.
- release: `Q_FULL` to `Q_PARTIAL`, on a pop with no push.
- hold: stay in the same state. This covers an overflow in either mode and a push with a pop in the same cycle.

Top module: `key_event_queue`

## Requirements
- R1: After reset, `ev_count` is 0, `pop_data` is 0x00, `ovf_flag` is 0 and `ovf_irq` is 0.
- R2: Events are popped in arrival order. Each 8-bit value comes back unchanged: bit 7 is 1 for a press and 0 for a release, and bits 6:0 hold the key code. `pop_data` shows the popped event on the cycle after `pop_req`.
- R3: The queue holds up to ten events. `ev_count` equals the number of pending events, from 0 to 10, and is updated on the cycle after each push or pop.
- R4: A pop while the queue is empty returns 0x00 and leaves `ev_count` unchanged. A push in that same cycle is still stored.
- R5: With `shift_mode` = 0, a push into a full queue with no pop is discarded. The count stays 10 and the stored contents do not change.
- R6: With `shift_mode` = 1, a push into a full queue with no pop is stored. The oldest event is removed and the count stays 10.
- R7: A push and a pop in the same cycle on a full queue serve the pop first. The oldest event is returned, the new event is stored, and no overflow is raised in either mode.
- R8: `ovf_flag` goes to 1 on the cycle after any overflow and stays 1 until a cycle with `ovf_clr` = 1. If an overflow and a clear happen in the same cycle, the flag is set.
- R9: `ovf_irq` is high for exactly the one cycle after an overflow, and only if `ovf_irq_en` was 1 in the overflow cycle.
- R10: A push and a pop in the same cycle on a partly filled queue leave `ev_count` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| push_valid | input | 1 | An event is offered this cycle |
| push_code | input | 8 | Event value: bit 7 press/release, bits 6:0 key code |
| pop_req | input | 1 | Host pops the oldest event |
| shift_mode | input | 1 | 0 = drop the new event on overflow, 1 = discard the oldest event |
| ovf_irq_en | input | 1 | Enables the overflow interrupt request |
| ovf_clr | input | 1 | Write-1 clear of the overflow flag |
| pop_data | output | 8 | Event returned by the last pop (0x00 if the queue was empty) |
| ev_count | output | 4 | Number of pending events |
| ovf_flag | output | 1 | Sticky overflow status |
| ovf_irq | output | 1 | One-cycle overflow interrupt request |

## Verification
Every result has one cycle of latency. `pop_data`, `ev_count`, `ovf_flag` and `ovf_irq` all reflect the inputs sampled at the previous rising edge.

The driver applies each stimulus at a falling edge. Just after the next rising edge, it updates a reference queue and enqueues the expected values. A monitor compares them at the following falling edge, so each comparison lands exactly one register stage after its stimulus. Because `ovf_irq` is a single-cycle pulse, the idle cycle after an overflow is checked explicitly for its return to 0.

// File: rtl/kq_pkg.sv
package kq_pkg;
    typedef enum logic [1:0] {
        Q_EMPTY   = 2'd0,
        Q_PARTIAL = 2'd1,
        Q_FULL    = 2'd2
    } kq_state_e;
endpackage

// File: rtl/kq_ctrl.sv
module kq_ctrl #(
    parameter int DEPTH = 10,
    parameter int AW    = 4,
    parameter int CW    = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_valid,
    input  logic          pop_req,
    input  logic          shift_mode,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [AW-1:0] rd_addr,
    output logic          rd_take,
    output logic          overflow,
    output logic [CW-1:0] count
);
    import kq_pkg::*;

    kq_state_e     state_q, state_d;
    logic [AW-1:0] wr_q, rd_q;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          drop_old;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    // state register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= Q_EMPTY;
            cnt_q   <= '0;
            wr_q    <= '0;
            rd_q    <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            if (wr_en)              wr_q <= bump(wr_q);
            if (rd_take || drop_old) rd_q <= bump(rd_q);
        end
    end

    // output and next-state process
    always_comb begin
        wr_en    = 1'b0;
        rd_take  = 1'b0;
        overflow = 1'b0;
        drop_old = 1'b0;
        unique case (state_q)
            Q_EMPTY: begin
                wr_en = push_valid;
            end
            Q_PARTIAL: begin
                wr_en   = push_valid;
                rd_take = pop_req;
            end
            Q_FULL: begin
                rd_take  = pop_req;
                overflow = push_valid && !pop_req;
                wr_en    = push_valid && (pop_req || shift_mode);
                drop_old = overflow && shift_mode;
            end
            default: ;
        endcase
        cnt_d = cnt_q + CW'(wr_en) - CW'(rd_take) - CW'(drop_old);
        if (cnt_d == '0)
            state_d = Q_EMPTY;
        else if (cnt_d == CW'(DEPTH))
            state_d = Q_FULL;
        else
            state_d = Q_PARTIAL;
    end

    assign wr_addr = wr_q;
    assign rd_addr = rd_q;
    assign count   = cnt_q;
endmodule

// File: rtl/kq_store.sv
module kq_store #(
    parameter int DEPTH = 10,
    parameter int EV_W  = 8,
    parameter int AW    = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [AW-1:0]   wr_addr,
    input  logic [EV_W-1:0] wr_data,
    input  logic            rd_req,
    input  logic            rd_take,
    input  logic [AW-1:0]   rd_addr,
    output logic [EV_W-1:0] rd_data
);
    logic [DEPTH-1:0][EV_W-1:0] cells;

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        logic [EV_W-1:0] cell_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                cell_q <= '0;
            else if (wr_en && wr_addr == AW'(g))
                cell_q <= wr_data;
        end
        assign cells[g] = cell_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rd_data <= '0;
        else if (rd_req)
            rd_data <= rd_take ? cells[rd_addr] : '0;
    end
endmodule

// File: rtl/kq_ovf.sv
module kq_ovf (
    input  logic clk,
    input  logic rst_n,
    input  logic overflow,
    input  logic clr,
    input  logic irq_en,
    output logic flag,
    output logic irq
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag <= 1'b0;
            irq  <= 1'b0;
        end else begin
            if (overflow)
                flag <= 1'b1;
            else if (clr)
                flag <= 1'b0;
            irq <= overflow && irq_en;
        end
    end
endmodule

// File: rtl/key_event_queue.sv
module key_event_queue #(
    parameter int DEPTH = 10,
    parameter int EV_W  = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push_valid,
    input  logic [EV_W-1:0]            push_code,
    input  logic                       pop_req,
    input  logic                       shift_mode,
    input  logic                       ovf_irq_en,
    input  logic                       ovf_clr,
    output logic [EV_W-1:0]            pop_data,
    output logic [$clog2(DEPTH+1)-1:0] ev_count,
    output logic                       ovf_flag,
    output logic                       ovf_irq
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic          wr_en, rd_take, overflow;
    logic [AW-1:0] wr_addr, rd_addr;

    kq_ctrl #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_valid (push_valid),
        .pop_req    (pop_req),
        .shift_mode (shift_mode),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .rd_addr    (rd_addr),
        .rd_take    (rd_take),
        .overflow   (overflow),
        .count      (ev_count)
    );

    kq_store #(.DEPTH(DEPTH), .EV_W(EV_W), .AW(AW)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (push_code),
        .rd_req  (pop_req),
        .rd_take (rd_take),
        .rd_addr (rd_addr),
        .rd_data (pop_data)
    );

    kq_ovf u_ovf (
        .clk      (clk),
        .rst_n    (rst_n),
        .overflow (overflow),
        .clr      (ovf_clr),
        .irq_en   (ovf_irq_en),
        .flag     (ovf_flag),
        .irq      (ovf_irq)
    );
endmodule

// File: rtl/kq_checker.sv
module kq_checker #(
    parameter int DEPTH = 10,
    parameter int EV_W  = 8,
    parameter int CW    = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            push_valid,
    input logic            pop_req,
    input logic            ovf_clr,
    input logic            ovf_irq_en,
    input logic [EV_W-1:0] pop_data,
    input logic [CW-1:0]   ev_count,
    input logic            ovf_flag,
    input logic            ovf_irq
);
    p_count_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ev_count <= CW'(DEPTH));

    p_empty_pop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pop_req && !push_valid && ev_count == '0 |=> pop_data == '0 && ev_count == '0);

    p_full_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
        push_valid && !pop_req && ev_count == CW'(DEPTH) |=> ev_count == CW'(DEPTH));

    p_full_swap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        push_valid && pop_req && ev_count == CW'(DEPTH) |=> ev_count == CW'(DEPTH) && !ovf_irq);

    p_ovf_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        push_valid && !pop_req && ev_count == CW'(DEPTH) |=> ovf_flag);

    p_ovf_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_flag && !ovf_clr |=> ovf_flag);

    p_irq_fire_r9: assert property (@(posedge clk) disable iff (!rst_n)
        push_valid && !pop_req && ev_count == CW'(DEPTH) && ovf_irq_en |=> ovf_irq);

    p_irq_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !ovf_irq_en |=> !ovf_irq);

    p_swap_count_r10: assert property (@(posedge clk) disable iff (!rst_n)
        push_valid && pop_req && ev_count != '0 |=> $stable(ev_count));
endmodule

bind key_event_queue kq_checker #(.DEPTH(DEPTH), .EV_W(EV_W), .CW(CW)) u_kq_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_valid (push_valid),
    .pop_req    (pop_req),
    .ovf_clr    (ovf_clr),
    .ovf_irq_en (ovf_irq_en),
    .pop_data   (pop_data),
    .ev_count   (ev_count),
    .ovf_flag   (ovf_flag),
    .ovf_irq    (ovf_irq)
);

// File: tb/key_event_queue_tb_top.sv
module key_event_queue_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       push_valid = 1'b0;
    logic [7:0] push_code = 8'h00;
    logic       pop_req = 1'b0;
    logic       shift_mode = 1'b0;
    logic       ovf_irq_en = 1'b0;
    logic       ovf_clr = 1'b0;
    logic [7:0] pop_data;
    logic [3:0] ev_count;
    logic       ovf_flag;
    logic       ovf_irq;

    int checks = 0;
    int errors = 0;

    // reference model state
    logic [7:0] model_q[$];
    bit         m_flag = 1'b0;

    // scoreboard queues of expected results
    bit         e_popchk[$];
    logic [7:0] e_pop[$];
    int         e_cnt[$];
    bit         e_flag[$];
    bit         e_irq[$];
    string      e_tag[$];

    always #2.5 clk = ~clk;

    key_event_queue dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_valid (push_valid),
        .push_code  (push_code),
        .pop_req    (pop_req),
        .shift_mode (shift_mode),
        .ovf_irq_en (ovf_irq_en),
        .ovf_clr    (ovf_clr),
        .pop_data   (pop_data),
        .ev_count   (ev_count),
        .ovf_flag   (ovf_flag),
        .ovf_irq    (ovf_irq)
    );

    task automatic check(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
        end
    endtask

    // driver: apply one cycle of stimulus, update the model, enqueue expectations
    task automatic step(bit pu, logic [7:0] code, bit po, bit clr, string tag);
        bit         ovf;
        logic [7:0] got;
        @(negedge clk);
        push_valid = pu;
        push_code  = code;
        pop_req    = po;
        ovf_clr    = clr;
        @(posedge clk);
        #1;
        ovf = 1'b0;
        got = 8'h00;
        if (po && model_q.size() > 0) got = model_q.pop_front();
        if (pu) begin
            if (model_q.size() < 10) model_q.push_back(code);
            else begin
                ovf = 1'b1;
                if (shift_mode) begin
                    void'(model_q.pop_front());
                    model_q.push_back(code);
                end
            end
        end
        if (ovf) m_flag = 1'b1;
        else if (clr) m_flag = 1'b0;
        e_popchk.push_back(po);
        e_pop.push_back(got);
        e_cnt.push_back(model_q.size());
        e_flag.push_back(m_flag);
        e_irq.push_back(ovf && ovf_irq_en);
        e_tag.push_back(tag);
    endtask

    // monitor: compare outputs one cycle after each stimulus
    always @(negedge clk) begin
        while (e_tag.size() > 0) begin
            string t;
            bit pc;
            t  = e_tag.pop_front();
            pc = e_popchk.pop_front();
            if (pc) check(t, "pop_data", int'(pop_data), int'(e_pop.pop_front()));
            else void'(e_pop.pop_front());
            check(t, "ev_count", int'(ev_count), e_cnt.pop_front());
            check(t, "ovf_flag", int'(ovf_flag), int'(e_flag.pop_front()));
            check(t, "ovf_irq", int'(ovf_irq), int'(e_irq.pop_front()));
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "ev_count", int'(ev_count), 0);
        check("R1", "pop_data", int'(pop_data), 0);
        check("R1", "ovf_flag", int'(ovf_flag), 0);
        check("R1", "ovf_irq", int'(ovf_irq), 0);

        shift_mode = 1'b0;
        ovf_irq_en = 1'b1;
        // order and value preservation
        step(1, 8'h81, 0, 0, "R2");
        step(1, 8'h05, 0, 0, "R2");
        step(1, 8'hC3, 0, 0, "R2");
        for (int i = 0; i < 3; i++) step(0, 8'h00, 1, 0, "R2");
        // empty pops
        step(0, 8'h00, 1, 0, "R4");
        step(1, 8'h90, 1, 0, "R4");
        step(1, 8'h11, 1, 0, "R10");
        step(0, 8'h00, 1, 0, "R10");
        // fill to capacity
        for (int i = 0; i < 10; i++)
            step(1, 8'(((i % 2) << 7) | (8'h20 + i)), 0, 0, "R3");
        // drop-mode overflow with interrupt enabled
        step(1, 8'h7F, 0, 0, "R5");
        step(0, 8'h00, 0, 0, "R9");
        step(0, 8'h00, 0, 1, "R8");
        // push and pop together while full
        step(1, 8'hAA, 1, 0, "R7");
        for (int i = 0; i < 10; i++) step(0, 8'h00, 1, 0, "R5");
        step(0, 8'h00, 1, 0, "R4");

        // shift mode, interrupt disabled
        shift_mode = 1'b1;
        ovf_irq_en = 1'b0;
        for (int i = 0; i < 10; i++) step(1, 8'h40 + 8'(i), 0, 0, "R3");
        step(1, 8'hE1, 0, 0, "R6");
        step(1, 8'h62, 0, 0, "R6");
        step(1, 8'h1C, 1, 0, "R7");
        ovf_irq_en = 1'b1;
        step(1, 8'hF3, 0, 1, "R8");
        step(0, 8'h00, 0, 0, "R9");
        step(0, 8'h00, 0, 1, "R8");
        for (int i = 0; i < 10; i++) step(0, 8'h00, 1, 0, "R6");
        step(0, 8'h00, 0, 0, "R3");
        @(negedge clk);
        @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule